// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block sits on the device side of a 16-bit parallel NOR flash interface and interprets the stream of bus writes the way the classic two-cycle-unlock command set expects. Each write carries a word address and a data word. The block walks the unlock, identification, query, program, sector erase, chip erase and unlock-bypass sequences. It applies their effect to a small register-based storage array organised in sectors. It also chooses what a read returns: array contents, identification codes, the query table, or polling status while an operation is still running.

Program and erase operations keep the block busy for a parameterised number of clock cycles. During that time array reads return toggle-bit status instead of data, and incoming writes are dropped. The bus is synchronous. A read strobe returns data on the following cycle, and the value is held until the next read strobe.

Top module: `nor_flash_cmd`

## Requirements
- R1: Only the low CMD_AW (default 11) address bits take part in command address matching. Writes to 0x5555 and 0x2AAA unlock exactly like writes to 0x555 and 0x2AA.
- R2: The identification entry sequence is 0xAA@0x555, 0x55@0x2AA, 0x90@0x555. After it, a read of word 0 returns 0x00BF and a read of word 1 returns 0x236D. Writing 0xF0 to any address returns the block to array reads.
- R3: 0x98 written to word 0x55 selects the query table. Words 0x10/0x11/0x12 read 0x0051/0x0052/0x0059 and word 0x2C reads 1. Words 0x2D/0x2E give SECTS-1 (low byte, then high byte), and words 0x2F/0x30 give the sector size in bytes divided by 256 (low byte, then high byte). 0xF0 exits.
- R4: A program is the unlock pair, 0xA0@0x555, then a data write at the target word. The stored word becomes old AND new, so 0x0055 followed by 0x00A5 leaves 0x0005.
- R5: An erase is the unlock pair, 0x80@0x555, the unlock pair again, and then one of two commands. 0x30 at any word of a sector sets that sector alone to 0xFFFF; 0x10@0x555 sets every word to 0xFFFF.
- R6: Any read while busy returns a status word with only bits 7 and 6 possibly set. Bit 7 is 0 for an erase and the inverse of bit 7 of the programmed data for a program. Bit 6 is 0 on the first status read of an operation and inverts on each later read strobe.
- R7: The busy output rises on the cycle after the accepted final write. It stays high for PROG_CYC cycles (program) or ERASE_CYC cycles (erase), and the next read after it falls returns array data.
- R8: Writes that arrive while busy change neither the command state nor the array.
- R9: The unlock pair followed by 0x20@0x555 enters bypass mode. In bypass, 0xA0 at any address followed by a data write programs that word, and 0x00 leaves bypass. After leaving, a lone 0xA0 plus data write has no effect.
- R10: A write that breaks an expected sequence (wrong address or data) returns the decoder to array reads and does not change the array.
- R11: rd_data is updated only in the cycle after a read strobe and holds its value otherwise.
- R12: While and after reset, busy is 0, rd_data is 0 and reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for addr/wdata |
| rd_en | input | 1 | Read strobe; rd_data valid the next cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data / command byte in bits 7:0 |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | Program or erase in progress |

## Verification
The sharpest overlap is a read strobe landing in the very cycle the busy counter takes its final step. That read must still return status, while the read one cycle later returns stored data. The bench starts a program, reads back to back across the whole busy window, and checks three status words with bit 6 alternating, then the data word, with busy already low at that point. A second overlap, bus writes arriving during a busy window, is covered by issuing a complete program sequence right after the first one. That second sequence must leave the stored word unchanged.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_UNL1,
    ST_UNL2,
    ST_IDENT,
    ST_QUERY,
    ST_PGM,
    ST_ERS,
    ST_ERS_UNL1,
    ST_ERS_UNL2,
    ST_BYP,
    ST_BYP_PGM
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PGM,
    OP_SERASE,
    OP_CERASE
  } flash_op_t;

  localparam logic [7:0] CMD_KEY_A      = 8'hAA;
  localparam logic [7:0] CMD_KEY_B      = 8'h55;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_QUERY      = 8'h98;
  localparam logic [7:0] CMD_EXIT       = 8'hF0;
  localparam logic [7:0] CMD_WRITE      = 8'hA0;
  localparam logic [7:0] CMD_ERS_SETUP  = 8'h80;
  localparam logic [7:0] CMD_ERS_SECTOR = 8'h30;
  localparam logic [7:0] CMD_ERS_CHIP   = 8'h10;
  localparam logic [7:0] CMD_BYP_ENTER  = 8'h20;
  localparam logic [7:0] CMD_BYP_LEAVE  = 8'h00;

  localparam logic [15:0] MFR_CODE = 16'h00BF;
  localparam logic [15:0] DEV_CODE = 16'h236D;

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_flash_pkg::*;
#(
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd,
  output seq_state_t        state,
  output flash_op_t         op
);

  localparam logic [CMD_AW-1:0] ADR_KEY_A = CMD_AW'(12'h555);
  localparam logic [CMD_AW-1:0] ADR_KEY_B = CMD_AW'(12'h2AA);
  localparam logic [CMD_AW-1:0] ADR_QUERY = CMD_AW'(12'h055);

  seq_state_t state_nxt;
  logic       at_a, at_b, at_q, take;

  assign at_a = (cmd_addr == ADR_KEY_A);
  assign at_b = (cmd_addr == ADR_KEY_B);
  assign at_q = (cmd_addr == ADR_QUERY);
  assign take = wr_en && !busy;

  always_comb begin
    state_nxt = state;
    op        = OP_NONE;
    if (take) begin
      case (state)
        ST_ARRAY: begin
          if (at_a && cmd == CMD_KEY_A)      state_nxt = ST_UNL1;
          else if (at_q && cmd == CMD_QUERY) state_nxt = ST_QUERY;
        end
        ST_UNL1: begin
          if (at_b && cmd == CMD_KEY_B) state_nxt = ST_UNL2;
          else                          state_nxt = ST_ARRAY;
        end
        ST_UNL2: begin
          state_nxt = ST_ARRAY;
          if (at_a) begin
            case (cmd)
              CMD_IDENT:     state_nxt = ST_IDENT;
              CMD_WRITE:     state_nxt = ST_PGM;
              CMD_ERS_SETUP: state_nxt = ST_ERS;
              CMD_BYP_ENTER: state_nxt = ST_BYP;
              default:       state_nxt = ST_ARRAY;
            endcase
          end
        end
        ST_IDENT, ST_QUERY: begin
          if (cmd == CMD_EXIT) state_nxt = ST_ARRAY;
        end
        ST_PGM: begin
          op        = OP_PGM;
          state_nxt = ST_ARRAY;
        end
        ST_ERS: begin
          if (at_a && cmd == CMD_KEY_A) state_nxt = ST_ERS_UNL1;
          else                          state_nxt = ST_ARRAY;
        end
        ST_ERS_UNL1: begin
          if (at_b && cmd == CMD_KEY_B) state_nxt = ST_ERS_UNL2;
          else                          state_nxt = ST_ARRAY;
        end
        ST_ERS_UNL2: begin
          state_nxt = ST_ARRAY;
          if (cmd == CMD_ERS_SECTOR)             op = OP_SERASE;
          else if (at_a && cmd == CMD_ERS_CHIP)  op = OP_CERASE;
        end
        ST_BYP: begin
          if (cmd == CMD_WRITE)          state_nxt = ST_BYP_PGM;
          else if (cmd == CMD_BYP_LEAVE) state_nxt = ST_ARRAY;
        end
        ST_BYP_PGM: begin
          op        = OP_PGM;
          state_nxt = ST_BYP;
        end
        default: state_nxt = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= ST_ARRAY;
    else if (take) state <= state_nxt;
  end

  assert_hold_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (state == $past(state)));

  assert_reset_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state == ST_ARRAY));

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer
  import nor_flash_pkg::*;
#(
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  flash_op_t op,
  input  logic      rd_en,
  input  logic      pgm_msb,
  output logic      busy,
  output logic      status_dq7,
  output logic      status_dq6
);

  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          tog, tog_nxt;
  logic          dq7_q, dq7_nxt;
  logic          load, upd;

  assign load = (op != OP_NONE);
  assign busy = (cnt != '0);
  assign upd  = load || busy;

  always_comb begin
    cnt_nxt = cnt;
    tog_nxt = tog;
    dq7_nxt = dq7_q;
    if (load) begin
      cnt_nxt = (op == OP_PGM) ? CW'(PROG_CYC) : CW'(ERASE_CYC);
      tog_nxt = 1'b0;
      dq7_nxt = (op == OP_PGM) ? ~pgm_msb : 1'b0;
    end else if (busy) begin
      cnt_nxt = cnt - 1'b1;
      if (rd_en) tog_nxt = ~tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      tog   <= 1'b0;
      dq7_q <= 1'b0;
    end else if (upd) begin
      cnt   <= cnt_nxt;
      tog   <= tog_nxt;
      dq7_q <= dq7_nxt;
    end
  end

  assign status_dq7 = dq7_q;
  assign status_dq6 = tog;

  assert_load_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  assert_dq6_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && !load) |=> (status_dq6 != $past(status_dq6)));

  assert_busy_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_flash_pkg::*;
#(
  parameter int SECTS      = 4,
  parameter int SECT_WORDS = 128,
  parameter int DW         = 16,
  localparam int NW        = SECTS * SECT_WORDS,
  localparam int AW        = $clog2(NW),
  localparam int SW        = $clog2(SECT_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  flash_op_t     op,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);

  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk) begin
    case (op)
      OP_CERASE: begin
        for (int i = 0; i < NW; i++) mem[i] <= '1;
      end
      OP_SERASE: begin
        for (int i = 0; i < SECT_WORDS; i++) mem[{waddr[AW-1:SW], SW'(i)}] <= '1;
      end
      OP_PGM: mem[waddr] <= mem[waddr] & wdata;
      default: ;
    endcase
  end

  assign rword = mem[raddr];

  assert_pgm_clears_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PGM) |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == '0));

  assert_sector_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SERASE) |=> (mem[$past(waddr)] == '1));

endmodule

// File: rtl/nor_id_query.sv
module nor_id_query
  import nor_flash_pkg::*;
#(
  parameter int SECTS      = 4,
  parameter int SECT_WORDS = 128
) (
  input  logic [7:0]  idx,
  output logic [15:0] id_word,
  output logic [15:0] query_word
);

  localparam logic [15:0] NSEC_M1 = 16'(SECTS - 1);
  localparam logic [15:0] SIZE256 = 16'((SECT_WORDS * 2) / 256);

  always_comb begin
    case (idx)
      8'h00:   id_word = MFR_CODE;
      8'h01:   id_word = DEV_CODE;
      default: id_word = 16'h0000;
    endcase
  end

  always_comb begin
    case (idx)
      8'h10:   query_word = 16'h0051;
      8'h11:   query_word = 16'h0052;
      8'h12:   query_word = 16'h0059;
      8'h2C:   query_word = 16'h0001;
      8'h2D:   query_word = {8'h00, NSEC_M1[7:0]};
      8'h2E:   query_word = {8'h00, NSEC_M1[15:8]};
      8'h2F:   query_word = {8'h00, SIZE256[7:0]};
      8'h30:   query_word = {8'h00, SIZE256[15:8]};
      default: query_word = 16'h0000;
    endcase
  end

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int CMD_AW     = 11,
  parameter int SECTS      = 4,
  parameter int SECT_WORDS = 128,
  parameter int PROG_CYC   = 3,
  parameter int ERASE_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rd_data,
  output logic              busy
);

  localparam int ARR_AW = $clog2(SECTS * SECT_WORDS);

  logic [1:0]  rst_sync;
  logic        rst_n_int;
  seq_state_t  state;
  flash_op_t   op;
  logic        dq7, dq6;
  logic [15:0] arr_word, id_word, query_word, rd_nxt;
  logic        unused_addr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign unused_addr_hi = ^addr[ADDR_W-1:CMD_AW];

  nor_cmd_seq #(.CMD_AW(CMD_AW)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en),
    .busy     (busy),
    .cmd_addr (addr[CMD_AW-1:0]),
    .cmd      (wdata[7:0]),
    .state    (state),
    .op       (op)
  );

  nor_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .op         (op),
    .rd_en      (rd_en),
    .pgm_msb    (wdata[7]),
    .busy       (busy),
    .status_dq7 (dq7),
    .status_dq6 (dq6)
  );

  nor_array #(.SECTS(SECTS), .SECT_WORDS(SECT_WORDS), .DW(16)) i_array (
    .clk   (clk),
    .rst_n (rst_n_int),
    .op    (op),
    .waddr (addr[ARR_AW-1:0]),
    .wdata (wdata),
    .raddr (addr[ARR_AW-1:0]),
    .rword (arr_word)
  );

  nor_id_query #(.SECTS(SECTS), .SECT_WORDS(SECT_WORDS)) i_idq (
    .idx        (addr[7:0]),
    .id_word    (id_word),
    .query_word (query_word)
  );

  always_comb begin
    if (busy) begin
      rd_nxt = {8'h00, dq7, dq6, 6'b000000};
    end else begin
      case (state)
        ST_IDENT: rd_nxt = id_word;
        ST_QUERY: rd_nxt = query_word;
        default:  rd_nxt = arr_word;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  rd_data <= 16'h0000;
    else if (rd_en)  rd_data <= rd_nxt;
  end

  assert_status_shape_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (busy && rd_en) |=> ((rd_data[15:8] == 8'h00) && (rd_data[5:0] == 6'h00)));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_en |=> $stable(rd_data));

  assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (!busy && rd_data == 16'h0000));

endmodule

// File: tb/test_nor_flash_cmd.sv
`timescale 1ns/1ps
module test_nor_flash_cmd;

  localparam int PROG_CYC  = 3;
  localparam int ERASE_CYC = 6;
  localparam int NVEC      = 90;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [14:0] addr;
  logic [15:0] wdata;
  logic [15:0] rd_data;
  logic        busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nor_flash_cmd #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_nor_flash_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .busy(busy)
  );

  // vector: {req[3:0], op[1:0] (0 write, 1 read-check, 2 wait), addr[14:0], data[15:0]}
  function automatic logic [36:0] v(int r, int o, int a, int d);
    return {4'(r), 2'(o), 15'(a), 16'(d)};
  endfunction

  localparam logic [36:0] VEC [NVEC] = '{
    // R5 chip erase, R6 status words
    v(5,0,'h555,'hAA), v(5,0,'h2AA,'h55), v(5,0,'h555,'h80),
    v(5,0,'h555,'hAA), v(5,0,'h2AA,'h55), v(5,0,'h555,'h10),
    v(6,1,'h000,'h0000), v(6,1,'h000,'h0040), v(7,2,0,8),
    v(5,1,'h000,'hFFFF), v(5,1,'h1FF,'hFFFF),
    // R4 program 0x55 then 0xA5
    v(4,0,'h555,'hAA), v(4,0,'h2AA,'h55), v(4,0,'h555,'hA0), v(4,0,'h080,'h0055),
    v(6,1,'h080,'h0080), v(7,2,0,4), v(4,1,'h080,'h0055),
    v(4,0,'h555,'hAA), v(4,0,'h2AA,'h55), v(4,0,'h555,'hA0), v(4,0,'h080,'h00A5),
    v(6,1,'h080,'h0000), v(6,1,'h080,'h0040), v(7,2,0,4), v(4,1,'h080,'h0005),
    // R2 identification
    v(2,0,'h555,'hAA), v(2,0,'h2AA,'h55), v(2,0,'h555,'h90),
    v(2,1,'h000,'h00BF), v(2,1,'h001,'h236D), v(2,0,'h000,'hF0), v(2,1,'h080,'h0005),
    // R3 query table
    v(3,0,'h055,'h98), v(3,1,'h010,'h0051), v(3,1,'h011,'h0052), v(3,1,'h012,'h0059),
    v(3,1,'h02C,'h0001), v(3,1,'h02D,'h0003), v(3,1,'h02E,'h0000), v(3,1,'h02F,'h0001),
    v(3,1,'h030,'h0000), v(3,0,'h000,'hF0), v(3,1,'h080,'h0005),
    // R9 bypass mode
    v(9,0,'h555,'hAA), v(9,0,'h2AA,'h55), v(9,0,'h555,'h20), v(9,0,'h555,'hA0),
    v(9,0,'h000,'h0123), v(9,2,0,4), v(9,0,'h1AB,'hA0), v(9,0,'h001,'h4567),
    v(9,2,0,4), v(9,0,'h000,'h0000), v(9,0,'h555,'hA0), v(9,0,'h002,'h0089),
    v(9,1,'h000,'h0123), v(9,1,'h001,'h4567), v(9,1,'h002,'hFFFF),
    // R1 upper address bits ignored
    v(1,0,'h5555,'hAA), v(1,0,'h2AAA,'h55), v(1,0,'h5555,'h90),
    v(1,1,'h000,'h00BF), v(1,0,'h000,'hF0),
    // R10 broken sequence
    v(10,0,'h555,'hAA), v(10,0,'h2AB,'h55), v(10,0,'h555,'hA0), v(10,0,'h003,'h0000),
    v(10,1,'h003,'hFFFF), v(10,1,'h000,'h0123),
    // R8 writes during busy dropped
    v(8,0,'h555,'hAA), v(8,0,'h2AA,'h55), v(8,0,'h555,'hA0), v(8,0,'h004,'h00F0),
    v(8,0,'h555,'hAA), v(8,0,'h2AA,'h55), v(8,0,'h555,'hA0), v(8,0,'h004,'h0000),
    v(8,2,0,2), v(8,1,'h004,'h00F0),
    // R5 sector erase of sector 0 only
    v(5,0,'h555,'hAA), v(5,0,'h2AA,'h55), v(5,0,'h555,'h80),
    v(5,0,'h555,'hAA), v(5,0,'h2AA,'h55), v(5,0,'h005,'h30),
    v(7,2,0,8), v(5,1,'h000,'hFFFF), v(5,1,'h004,'hFFFF), v(5,1,'h080,'h0005)
  };

  task automatic check(int req, string what, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [14:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock_pair();
    wr(15'h555, 16'h00AA);
    wr(15'h2AA, 16'h0055);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [36:0] e;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(12, "rd_data in reset", rd_data, 16'h0000);
    check(12, "busy in reset", {15'h0, busy}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(12, "busy after reset", {15'h0, busy}, 16'h0000);
    check(12, "rd_data after reset", rd_data, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      e = VEC[i];
      case (e[32:31])
        2'd0: wr(e[30:16], e[15:0]);
        2'd1: begin
          rd(e[30:16]);
          check(int'(e[36:33]), $sformatf("vector %0d read @%h", i, e[30:16]), rd_data, e[15:0]);
        end
        default: repeat (int'(e[15:0])) @(negedge clk);
      endcase
    end

    // R11: no read strobe, rd_data holds
    rd(15'h080);
    repeat (3) @(negedge clk);
    addr = 15'h000;
    @(negedge clk);
    check(11, "rd_data held without strobe", rd_data, 16'h0005);

    // R7/R6: reads across the whole program busy window, last one at expiry
    unlock_pair();
    wr(15'h555, 16'h00A0);
    wr(15'h100, 16'h7F0F);
    check(7, "busy right after data write", {15'h0, busy}, 16'h0001);
    rd(15'h100);
    check(6, "status read 1", rd_data, 16'h0080);
    rd(15'h100);
    check(6, "status read 2", rd_data, 16'h00C0);
    rd(15'h100);
    check(6, "status read at expiry", rd_data, 16'h0080);
    check(7, "busy low with last status", {15'h0, busy}, 16'h0000);
    rd(15'h100);
    check(4, "data after program", rd_data, 16'h7F0F);

    // R7: program busy length
    unlock_pair();
    wr(15'h555, 16'h00A0);
    wr(15'h101, 16'h1234);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(7, "program busy cycles", 16'(n), 16'(PROG_CYC));

    // R7/R5: sector erase busy length, sector 3
    unlock_pair();
    wr(15'h555, 16'h0080);
    unlock_pair();
    wr(15'h180, 16'h0030);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(7, "erase busy cycles", 16'(n), 16'(ERASE_CYC));
    rd(15'h1C4);
    check(5, "sector 3 blank", rd_data, 16'hFFFF);
    rd(15'h101);
    check(5, "sector 2 kept", rd_data, 16'h1234);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule